// File: doc/BRIEF.md
# Four-Beat Burst Address Sequencer

This block produces the low-order address bits of a memory burst. A controller presents the low bits of a start address together with a load strobe. After that, each step strobe moves the burst on by one beat. The block emits the address bits for the current beat and a beat index that counts from zero. The index wraps after the last beat, so the burst returns to the address it started from.

A static order select picks between two orders. Linear order adds the beat count to the start value and wraps modulo the burst length. Interleaved order XORs the start value with the beat count. A freeze input stalls the sequencer, which then keeps both its address and its beat index for as long as the input is high. The reset is asserted asynchronously; internally its release is synchronised, and the block leaves reset two clock edges after the reset pin goes high.

Top module: `burst_addr_gen`

## Requirements
- R1: While reset is asserted, and after reset until the first load, burst_addr and beat_idx are both 0.
- R2: A clock edge with freeze low and load high captures load_addr as the start value. From the next cycle, beat_idx is 0 and burst_addr equals that start value in either order.
- R3: A clock edge with freeze low, load low and step high, after at least one load since reset, increments beat_idx by one modulo 4.
- R4: With order_sel low (linear), burst_addr equals (start + beat_idx) modulo 4. Starting at 01, this gives 01, 10, 11, 00.
- R5: With order_sel high (interleaved), burst_addr equals start XOR beat_idx. Starting at 01, this gives 01, 00, 11, 10.
- R6: Four steps after a load, beat_idx is 0 again and burst_addr equals the start value again.
- R7: A clock edge with freeze high leaves both burst_addr and beat_idx unchanged, whatever load, step and load_addr are.
- R8: When load and step are both high with freeze low, the load wins: the start value is replaced and beat_idx goes to 0.
- R9: A step strobe given before any load since reset has no effect. Both outputs stay 0.
- R10: order_sel is static. It may change only while reset is asserted.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| order_sel | input | 1 | Burst order: 0 linear, 1 interleaved; static outside reset |
| freeze | input | 1 | Stall: when high, all state holds |
| load | input | 1 | Capture load_addr as a new burst start |
| step | input | 1 | Advance to the next beat of an active burst |
| load_addr | input | BEAT_W (2) | Low bits of the external start address |
| burst_addr | output | BEAT_W (2) | Address bits of the current beat |
| beat_idx | output | BEAT_W (2) | Beats taken since the last load, modulo 4 |

## Verification
The assertions take for granted that order_sel holds still whenever reset is released. They also assume that the control strobes are always known, so that a stall, a load or a step is decoded without ambiguity. The stimulus changes order_sel only while rst_n is low, and waits for the internal reset release before it issues a command. The random phase draws freeze, load, step and load_addr freely on every cycle, so freeze is exercised against every combination of load and step, and load against step. The directed phase walks all four start values in both orders and checks that each burst returns to its start.

// File: rtl/burst_pkg.sv
package burst_pkg;

  // Command decoded each cycle from the strobes; freeze outranks load,
  // load outranks step.
  typedef enum logic [1:0] {
    CMD_IDLE   = 2'd0,
    CMD_LOAD   = 2'd1,
    CMD_STEP   = 2'd2,
    CMD_FREEZE = 2'd3
  } burst_cmd_e;

  typedef enum logic {
    ORDER_LINEAR      = 1'b0,
    ORDER_INTERLEAVED = 1'b1
  } burst_order_e;

endpackage

// File: rtl/burst_ctrl.sv
module burst_ctrl
  import burst_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       freeze,
  input  logic       load,
  input  logic       step,
  output burst_cmd_e cmd,
  output logic       active
);

  logic active_q, active_d;

  always_comb begin
    if (freeze)                cmd = CMD_FREEZE;
    else if (load)             cmd = CMD_LOAD;
    else if (step && active_q) cmd = CMD_STEP;
    else                       cmd = CMD_IDLE;
  end

  always_comb begin
    active_d = active_q;
    if (cmd == CMD_LOAD) active_d = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) active_q <= 1'b0;
    else        active_q <= active_d;
  end

  assign active = active_q;

  // Once a burst has been loaded it stays active until reset (R9 gating).
  p_active_sticky_r9: assert property (@(posedge clk) disable iff (!rst_n)
    active_q |=> active_q);

  // Freeze holds the active flag too (R7).
  p_active_freeze_r7: assert property (@(posedge clk) disable iff (!rst_n)
    freeze |=> $stable(active_q));

endmodule

// File: rtl/burst_seed_reg.sv
module burst_seed_reg
  import burst_pkg::*;
#(
  parameter int BEAT_W = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  burst_cmd_e        cmd,
  input  logic [BEAT_W-1:0] start_in,
  output logic [BEAT_W-1:0] seed
);

  logic [BEAT_W-1:0] seed_q, seed_d;

  always_comb begin
    seed_d = seed_q;
    if (cmd == CMD_LOAD) seed_d = start_in;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) seed_q <= '0;
    else        seed_q <= seed_d;
  end

  assign seed = seed_q;

  p_seed_capture_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd == CMD_LOAD) |=> (seed_q == $past(start_in)));

  p_seed_keep_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd != CMD_LOAD) |=> $stable(seed_q));

endmodule

// File: rtl/burst_beat_ctr.sv
module burst_beat_ctr
  import burst_pkg::*;
#(
  parameter int BEAT_W = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  burst_cmd_e        cmd,
  output logic [BEAT_W-1:0] beat
);

  logic [BEAT_W-1:0] beat_q, beat_d;

  always_comb begin
    unique case (cmd)
      CMD_LOAD: beat_d = '0;
      CMD_STEP: beat_d = beat_q + BEAT_W'(1);
      default:  beat_d = beat_q;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) beat_q <= '0;
    else        beat_q <= beat_d;
  end

  assign beat = beat_q;

  p_beat_clear_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd == CMD_LOAD) |=> (beat_q == '0));

  p_beat_step_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd == CMD_STEP) |=> (beat_q == BEAT_W'($past(beat_q) + 1)));

  p_beat_freeze_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd == CMD_FREEZE) |=> $stable(beat_q));

  p_beat_idle_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd == CMD_IDLE) |=> $stable(beat_q));

endmodule

// File: rtl/burst_order_map.sv
module burst_order_map
  import burst_pkg::*;
#(
  parameter int BEAT_W = 2
) (
  input  burst_order_e      order,
  input  logic [BEAT_W-1:0] seed,
  input  logic [BEAT_W-1:0] beat,
  output logic [BEAT_W-1:0] addr
);

  logic [BEAT_W-1:0] lin_addr;
  logic [BEAT_W-1:0] il_addr;

  // Linear: modular add, carry out of the top bit dropped.
  assign lin_addr = seed + beat;

  // Interleaved: per-bit toggle of the seed by the beat count.
  for (genvar b = 0; b < BEAT_W; b++) begin : g_il_bit
    assign il_addr[b] = seed[b] ^ beat[b];
  end

  always_comb begin
    if (order == ORDER_INTERLEAVED) addr = il_addr;
    else                            addr = lin_addr;
  end

endmodule

// File: rtl/burst_addr_gen.sv
module burst_addr_gen
  import burst_pkg::*;
#(
  parameter int BEAT_W = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              order_sel,
  input  logic              freeze,
  input  logic              load,
  input  logic              step,
  input  logic [BEAT_W-1:0] load_addr,
  output logic [BEAT_W-1:0] burst_addr,
  output logic [BEAT_W-1:0] beat_idx
);

  localparam logic [BEAT_W-1:0] LAST_BEAT = {BEAT_W{1'b1}};

  logic [1:0]        rst_sync_q;
  logic              rst_int_n;
  burst_cmd_e        cmd;
  logic              active;
  logic [BEAT_W-1:0] seed;
  logic [BEAT_W-1:0] beat;
  burst_order_e      order;

  // Asynchronous assert, two-flop synchronous release.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_int_n = rst_sync_q[1];

  assign order = burst_order_e'(order_sel);

  burst_ctrl u_ctrl (
    .clk    (clk),
    .rst_n  (rst_int_n),
    .freeze (freeze),
    .load   (load),
    .step   (step),
    .cmd    (cmd),
    .active (active)
  );

  burst_seed_reg #(.BEAT_W(BEAT_W)) u_seed (
    .clk      (clk),
    .rst_n    (rst_int_n),
    .cmd      (cmd),
    .start_in (load_addr),
    .seed     (seed)
  );

  burst_beat_ctr #(.BEAT_W(BEAT_W)) u_beat (
    .clk   (clk),
    .rst_n (rst_int_n),
    .cmd   (cmd),
    .beat  (beat)
  );

  burst_order_map #(.BEAT_W(BEAT_W)) u_map (
    .order (order),
    .seed  (seed),
    .beat  (beat),
    .addr  (burst_addr)
  );

  assign beat_idx = beat;

  p_mode_static_r10: assert property (@(posedge clk) disable iff (!rst_int_n)
    1'b1 |=> $stable(order_sel));

  p_first_beat_r4: assert property (@(posedge clk) disable iff (!rst_int_n)
    (beat_idx == '0) |-> (burst_addr == seed));

  p_wrap_r6: assert property (@(posedge clk) disable iff (!rst_int_n)
    (cmd == CMD_STEP && beat_idx == LAST_BEAT) |=> (burst_addr == seed && beat_idx == '0));

  p_no_step_idle_r9: assert property (@(posedge clk) disable iff (!rst_int_n)
    (!active && !load) |=> (beat_idx == '0 && burst_addr == '0));

  p_load_wins_r8: assert property (@(posedge clk) disable iff (!rst_int_n)
    (!freeze && load && step) |=> (beat_idx == '0 && burst_addr == $past(load_addr)));

endmodule

// File: tb/burst_addr_gen_tb.sv
`timescale 1ns/1ps
module burst_addr_gen_tb;

  logic       clk = 1'b0;
  logic       rst_n;
  logic       order_sel;
  logic       freeze;
  logic       load;
  logic       step;
  logic [1:0] load_addr;
  logic [1:0] burst_addr;
  logic [1:0] beat_idx;

  int checks = 0;
  int errors = 0;

  logic [1:0] m_seed;
  logic [1:0] m_beat;
  logic       m_active;

  always #4 clk = ~clk;

  burst_addr_gen #(.BEAT_W(2)) u_dut (
    .clk        (clk),
    .rst_n      (rst_n),
    .order_sel  (order_sel),
    .freeze     (freeze),
    .load       (load),
    .step       (step),
    .load_addr  (load_addr),
    .burst_addr (burst_addr),
    .beat_idx   (beat_idx)
  );

  function automatic logic [1:0] exp_addr(input logic il, input logic [1:0] s, input logic [1:0] b);
    if (il) return s ^ b;
    return 2'((s + b) & 2'b11);
  endfunction

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic chk_state(input string tag);
    chk(tag, int'(beat_idx), int'(m_beat));
    chk(tag, int'(burst_addr), int'(exp_addr(order_sel, m_seed, m_beat)));
  endtask

  // Called at a negedge: drive, let one posedge pass, update model, compare.
  task automatic cyc(input logic f, input logic l, input logic s, input logic [1:0] a);
    freeze = f; load = l; step = s; load_addr = a;
    @(negedge clk);
    if (!f) begin
      if (l) begin
        m_seed = a; m_beat = 2'd0; m_active = 1'b1;
      end else if (s && m_active) begin
        m_beat = m_beat + 2'd1;
      end
    end
  endtask

  task automatic do_reset(input logic il);
    rst_n = 1'b0; freeze = 0; load = 0; step = 0; load_addr = 0;
    order_sel = il;
    repeat (3) @(negedge clk);
    chk("R1 reset addr", int'(burst_addr), 0);
    chk("R1 reset beat", int'(beat_idx), 0);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    m_seed = 0; m_beat = 0; m_active = 0;
    chk_state("R1 after release");
  endtask

  task automatic run_mode(input logic il);
    string tord;
    tord = il ? "R5" : "R4";
    do_reset(il);
    // R9: step before any load
    cyc(0, 0, 1, 2'd3);
    chk("R9 idle step beat", int'(beat_idx), 0);
    cyc(0, 0, 1, 2'd2);
    chk("R9 idle step addr", int'(burst_addr), 0);
    // every start value, full burst plus wrap
    for (int st = 0; st < 4; st++) begin
      cyc(0, 1, 0, 2'(st));
      chk("R2 load addr", int'(burst_addr), st);
      chk("R2 load beat", int'(beat_idx), 0);
      for (int k = 1; k <= 4; k++) begin
        cyc(0, 0, 1, 2'd0);
        chk({tord, " order"}, int'(burst_addr), int'(exp_addr(il, 2'(st), 2'(k))));
        chk("R3 beat", int'(beat_idx), k % 4);
      end
      chk("R6 wrap to start", int'(burst_addr), st);
    end
    // documented example starting at 01
    cyc(0, 1, 0, 2'd1);
    for (int k = 0; k < 4; k++) begin
      int lit;
      if (il) lit = (k == 0) ? 1 : (k == 1) ? 0 : (k == 2) ? 3 : 2;
      else    lit = (k == 0) ? 1 : (k == 1) ? 2 : (k == 2) ? 3 : 0;
      chk({tord, " example"}, int'(burst_addr), lit);
      cyc(0, 0, 1, 2'd0);
    end
    // R8: load and step together
    cyc(0, 0, 1, 2'd0);
    cyc(0, 1, 1, 2'd2);
    chk("R8 load wins addr", int'(burst_addr), 2);
    chk("R8 load wins beat", int'(beat_idx), 0);
    // R7: freeze against load and step
    cyc(0, 0, 1, 2'd0);
    cyc(1, 1, 1, 2'd3);
    chk("R7 freeze beat", int'(beat_idx), 1);
    chk("R7 freeze addr", int'(burst_addr), int'(exp_addr(il, 2'd2, 2'd1)));
    cyc(1, 0, 1, 2'd0);
    chk("R7 freeze step beat", int'(beat_idx), 1);
    // random traffic
    for (int n = 0; n < 400; n++) begin
      logic f, l, s;
      f = ($urandom % 4) == 0;
      l = ($urandom % 5) == 0;
      s = ($urandom % 3) != 0;
      cyc(f, l, s, 2'($urandom));
      chk_state(il ? "R5 random" : "R4 random");
      chk("R3 random beat", int'(beat_idx), int'(m_beat));
    end
  endtask

  initial begin
    #(200000 * 8);
    errors++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    void'($urandom(32'h5eed_1234));
    rst_n = 1'b0; order_sel = 0; freeze = 0; load = 0; step = 0; load_addr = 0;
    m_seed = 0; m_beat = 0; m_active = 0;
    @(negedge clk);
    run_mode(1'b0);
    run_mode(1'b1);
    // R10: order switched only under reset, new order honoured
    do_reset(1'b0);
    cyc(0, 1, 0, 2'd3);
    cyc(0, 0, 1, 2'd0);
    chk("R10 linear after reset", int'(burst_addr), 0);
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule